// File: doc/BRIEF.md
# Quiz Buzzer Core for Four Contestants

This block runs the answer window of a four-contestant quiz buzzer. The host resets the block and then pulses a start input. While the window is open, a two-digit BCD timer counts down from 60, moving one step on each one-second tick enable. The first contestant whose button is seen while the window is open wins. The winner's number is held, the timer returns to 60, and every later press is ignored until the next host reset. If the timer reaches 00 with no press, the block goes back to idle and no winner is recorded.

The buttons are assumed to be already debounced. They pass through a two-flop synchronizer before the priority logic looks at them. Display decoding, digit multiplexing and tick generation belong to neighbouring blocks. All pins are plain level signals: there is no data stream here, so no valid/ready handshake and no back-pressure.

Top module: `quiz_buzzer_core`

## Requirements
- R1: While reset is held and right after it, the timer shows tens=6, ones=0, the winner code is 0, and both counting_o and locked_o are low.
- R2: A start_i high in idle sets counting_o on the next clock edge. Start has no effect in the counting or locked states.
- R3: While counting, each cycle with tick_i high lowers the BCD count by one. When ones is 0, ones wraps to 9 and tens drops by one on the same tick, so 60 is followed by 59 and 50 is followed by 49.
- R4: When the count reaches 00 with no press, the block returns to idle on the next edge and the timer reloads to 60 on the edge after that. The winner code stays 0.
- R5: A press seen while counting stores the contestant number as a binary winner code (button bit 0 gives 1, bit 1 gives 2, bit 2 gives 3, bit 3 gives 4) and enters the locked state. The timer shows 60 one edge later.
- R6: When several synchronized buttons are high in the same cycle, the lowest button bit wins. Contestant 1 has the highest priority and contestant 4 the lowest.
- R7: The locked state lasts until reset. While locked, the winner code does not change under new presses, and start is ignored.
- R8: Button presses in idle do not change the winner code and do not start or lock the block.
- R9: Button inputs pass through two synchronizer flops. A press driven just after an edge reaches locked_o and winner_o on the third edge, and not before.
- R10: tick_i has no effect on the timer outside the counting state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Host reset, active low, asynchronous |
| start_i | input | 1 | Host start request, level |
| tick_i | input | 1 | One-second tick enable, one cycle wide |
| btn_i | input | 4 | Contestant buttons, bit 0 is contestant 1 |
| tens_o | output | 4 | Countdown tens digit, BCD |
| ones_o | output | 4 | Countdown ones digit, BCD |
| winner_o | output | 4 | Winning contestant number, 0 when there is none |
| counting_o | output | 1 | Answer window open |
| locked_o | output | 1 | Winner captured, waiting for reset |

## Verification
The assertions assume that reset is the only way out of the locked state and that start_i and tick_i are ordinary synchronous levels. They do not constrain btn_i, because the synchronizer absorbs any timing. The bench changes every input on the falling clock edge and keeps each tick one cycle wide. Before each start it releases all buttons and lets the synchronizer drain, so that a press only counts when a scenario means it to.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOCK = 2'd2
  } quiz_state_t;

  localparam int DIGIT_W = 4;
  localparam int BCD_MAX = 9;
endpackage

// File: rtl/quiz_btn_sync.sv
module quiz_btn_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/quiz_bcd_timer.sv
module quiz_bcd_timer
  import quiz_pkg::*;
#(
  parameter int START_TENS = 6,
  parameter int START_ONES = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               tick_i,
  output logic [DIGIT_W-1:0] tens_o,
  output logic [DIGIT_W-1:0] ones_o,
  output logic               zero_o
);
  localparam logic [DIGIT_W-1:0] LOAD_T = DIGIT_W'(START_TENS);
  localparam logic [DIGIT_W-1:0] LOAD_O = DIGIT_W'(START_ONES);
  localparam logic [DIGIT_W-1:0] WRAP_O = DIGIT_W'(BCD_MAX);

  assign zero_o = (tens_o == '0) && (ones_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_o <= LOAD_T;
      ones_o <= LOAD_O;
    end else if (!run_i) begin
      tens_o <= LOAD_T;
      ones_o <= LOAD_O;
    end else if (tick_i && !zero_o) begin
      if (ones_o == '0) begin
        ones_o <= WRAP_O;
        tens_o <= tens_o - 1'b1;
      end else begin
        ones_o <= ones_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/quiz_first_press.sv
module quiz_first_press #(
  parameter int PLAYERS = 4,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic [PLAYERS-1:0] btn_i,
  output logic               hit_o,
  output logic [CODE_W-1:0]  winner_o
);
  logic [CODE_W-1:0] code_d;

  assign hit_o = |btn_i;

  always_comb begin
    code_d = '0;
    for (int i = PLAYERS-1; i >= 0; i--) begin
      if (btn_i[i]) code_d = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winner_o <= '0;
    end else if (capture_i && hit_o) begin
      winner_o <= code_d;
    end
  end
endmodule

// File: rtl/quiz_ctrl.sv
module quiz_ctrl
  import quiz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hit_i,
  input  logic zero_i,
  output logic run_o,
  output logic lock_o
);
  quiz_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (hit_i)       state_d = ST_LOCK;
        else if (zero_i) state_d = ST_IDLE;
      end
      ST_LOCK: state_d = ST_LOCK;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign run_o  = (state_q == ST_RUN);
  assign lock_o = (state_q == ST_LOCK);
endmodule

// File: rtl/quiz_buzzer_core.sv
module quiz_buzzer_core #(
  parameter int PLAYERS     = 4,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int START_TENS  = 6,
  parameter int START_ONES  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic [PLAYERS-1:0] btn_i,
  output logic [3:0]         tens_o,
  output logic [3:0]         ones_o,
  output logic [CODE_W-1:0]  winner_o,
  output logic               counting_o,
  output logic               locked_o
);
  logic [PLAYERS-1:0] btn_s;
  logic               hit;
  logic               zero;

  quiz_btn_sync #(.WIDTH(PLAYERS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(btn_i), .sync_o(btn_s)
  );

  quiz_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_i(hit),
    .zero_i(zero), .run_o(counting_o), .lock_o(locked_o)
  );

  quiz_bcd_timer #(.START_TENS(START_TENS), .START_ONES(START_ONES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(counting_o), .tick_i(tick_i),
    .tens_o(tens_o), .ones_o(ones_o), .zero_o(zero)
  );

  quiz_first_press #(.PLAYERS(PLAYERS), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .capture_i(counting_o), .btn_i(btn_s),
    .hit_o(hit), .winner_o(winner_o)
  );
endmodule

// File: rtl/quiz_buzzer_checker.sv
module quiz_buzzer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       tick_i,
  input logic [3:0] tens_o,
  input logic [3:0] ones_o,
  input logic [3:0] winner_o,
  input logic       counting_o,
  input logic       locked_o
);
  // R7: locked persists
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);

  // R5: after lock, timer is back at 60 and winner is valid
  assert_lock_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> (tens_o == 4'd6 && ones_o == 4'd0 && winner_o >= 4'd1 && winner_o <= 4'd4));

  // R7/R8: winner only moves on a cycle after counting was open
  assert_winner_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !counting_o |=> $stable(winner_o));

  // R2: idle without start stays idle
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting_o && !locked_o && !start_i) |=> (!counting_o && !locked_o));

  // R3: digits stay in BCD range
  assert_bcd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_o <= 4'd9 && tens_o <= 4'd6));

  // R10: timer frozen outside counting
  assert_idle_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting_o && !$past(counting_o) && !tick_i) |=> $stable({tens_o, ones_o}));

  // R1: states exclusive
  assert_state_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(counting_o && locked_o));
endmodule

bind quiz_buzzer_core quiz_buzzer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
  .tens_o(tens_o), .ones_o(ones_o), .winner_o(winner_o),
  .counting_o(counting_o), .locked_o(locked_o)
);

// File: tb/quiz_buzzer_core_tb.sv
`timescale 1ns/1ps
module quiz_buzzer_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] btn_i = 4'd0;
  logic [3:0] tens_o, ones_o, winner_o;
  logic       counting_o, locked_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  quiz_buzzer_core u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .btn_i(btn_i), .tens_o(tens_o), .ones_o(ones_o), .winner_o(winner_o),
    .counting_o(counting_o), .locked_o(locked_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_view(input string req, input int t, input int o, input int w,
                            input int c, input int l);
    check({req, " tens"}, tens_o, t);
    check({req, " ones"}, ones_o, o);
    check({req, " winner"}, winner_o, w);
    check({req, " counting"}, counting_o, c);
    check({req, " locked"}, locked_o, l);
  endtask

  task automatic do_reset();
    btn_i = 4'd0; start_i = 1'b0; tick_i = 1'b0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    step(1);
    start_i = 1'b0;
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1;
    step(1);
    tick_i = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    check_view("R1 in reset", 6, 0, 0, 0, 0);
    do_reset();
    check_view("R1 after reset", 6, 0, 0, 0, 0);
  endtask

  task automatic t_idle_ignore();
    do_reset();
    btn_i = 4'b0010;
    pulse_tick();
    pulse_tick();
    step(4);
    check_view("R8 R10 idle press and tick", 6, 0, 0, 0, 0);
    btn_i = 4'd0;
    step(4);
  endtask

  task automatic t_timeout();
    do_reset();
    pulse_start();
    check("R2 counting after start", counting_o, 1);
    for (int i = 1; i <= 60; i++) begin
      pulse_tick();
      if (i == 1)  check("R3 first tick", tens_o * 10 + ones_o, 59);
      if (i == 10) check("R3 value 50", tens_o * 10 + ones_o, 50);
      if (i == 11) begin
        check("R3 wrap tens", tens_o, 4);
        check("R3 wrap ones", ones_o, 9);
      end
    end
    check_view("R4 at zero", 0, 0, 0, 0, 0);
    step(1);
    check_view("R4 reload", 6, 0, 0, 0, 0);
    pulse_tick();
    check_view("R10 tick after timeout", 6, 0, 0, 0, 0);
    pulse_start();
    check("R2 restart", counting_o, 1);
  endtask

  task automatic t_lock();
    do_reset();
    pulse_start();
    pulse_tick(); pulse_tick(); pulse_tick();
    check("R3 three ticks", tens_o * 10 + ones_o, 57);
    btn_i = 4'b0100;
    step(2);
    check("R9 not yet locked", locked_o, 0);
    step(1);
    check("R9 R5 locked", locked_o, 1);
    check("R5 winner 3", winner_o, 3);
    step(1);
    check_view("R5 timer reload", 6, 0, 3, 0, 1);
    btn_i = 4'b0001;
    step(4);
    pulse_start();
    pulse_tick();
    step(3);
    check_view("R7 later press and start", 6, 0, 3, 0, 1);
    btn_i = 4'd0;
  endtask

  task automatic t_priority(input logic [3:0] pat, input int exp);
    do_reset();
    pulse_start();
    btn_i = pat;
    step(4);
    check("R6 priority winner", winner_o, exp);
    check("R6 locked", locked_o, 1);
    btn_i = 4'd0;
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_timeout();
    t_lock();
    t_priority(4'b1010, 2);
    t_priority(4'b1111, 1);
    t_priority(4'b1000, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule